// File: doc/BRIEF.md
# Slave FIFO Packet Commit Controller

This block sits on the write side of an outgoing endpoint buffer that an external master fills. On each rising edge of the interface clock it samples an endpoint address, a write strobe, a data word and a packet-end strobe. Words written to the selected endpoint build up the packet that is currently open. That packet is closed and handed to the outgoing queue in one of two ways. It closes automatically on the edge where its word count reaches a programmable threshold. It closes on request when the master raises packet end, which allows packets shorter than the threshold, down to a single word.

Closed packets wait in a four-entry queue. Each entry holds the packet's word count and an XOR signature of its data words. A consumer removes the oldest entry with a one-cycle pop. If packet end arrives on the edge that closes a packet automatically, or on the edge right after it, the request is dropped and a sticky error flag is raised. A short packet that follows an automatically closed one must therefore be ended two or more edges after the last word of the full packet.

Top module: `pkt_commit_ctrl`

## Requirements
- R1: With `auto_en` high, the edge that accepts the word bringing the open packet's count to `auto_len` queues a packet of that length and resets `cur_count` to 0. A threshold of 0 never closes a packet.
- R2: `pkt_end` closes the open packet at its current length when that length is 1 or more and shorter than the threshold. The packet is queued and `cur_count` returns to 0.
- R3: When a write and `pkt_end` are both accepted on one edge, the word is counted first and the queued length includes it.
- R4: `pkt_end` is ignored on the edge of an automatic close and on the edge directly after it. `pe_err` then goes to 1 and stays at 1 until reset. A word written on that edge is still counted. On the second edge after the close, `pkt_end` is honoured.
- R5: `pkt_end` while the open packet holds 0 words, outside the window of R4, queues nothing and leaves `pe_err` unchanged.
- R6: Writes and `pkt_end` are acted on only when `ep_addr` equals parameter `EP_ADDR` (default 0). Otherwise they change nothing.
- R7: The queue holds 4 entries and `q_full` is 1 when all of them are occupied. While the queue is full, writes and `pkt_end` are rejected, even if `pop` is high on the same edge. `q_empty` is 1 when the queue holds no entry. `pop` removes the oldest entry, and the queue is first in, first out.
- R8: `auto_len` resets to 512. It loads `thr_value` on an edge where `thr_load` is high, but only if `cur_count` is 0 before that edge. Otherwise the load is ignored.
- R9: `pop_sig` is the bitwise XOR of all data words of the head packet. `pop_len` is that packet's word count. Both are valid while `q_empty` is 0.
- R10: After reset, `cur_count` is 0, `q_empty` is 1, `q_full` is 0 and `pe_err` is 0.
- R11: A write is rejected while `cur_count` is 1023, so the count saturates there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_en | input | 1 | Enables closing packets at the threshold |
| thr_load | input | 1 | Request to load a new threshold |
| thr_value | input | 10 | Threshold value to load |
| ep_addr | input | 2 | Endpoint address of the current access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Data word |
| pkt_end | input | 1 | Packet-end strobe |
| pop | input | 1 | Consumer removes the head packet |
| pop_len | output | 10 | Word count of the head packet |
| pop_sig | output | 16 | XOR signature of the head packet |
| q_empty | output | 1 | No packet is waiting |
| q_full | output | 1 | All queue entries are occupied |
| cur_count | output | 10 | Words in the open packet |
| auto_len | output | 10 | Current threshold |
| pe_err | output | 1 | Sticky flag for a dropped packet end |

## Verification
The bench targets packet end on the closing edge, on the edge after it, and two edges after it. A design with the window one edge too short would send the short packet that should be dropped, and one with the window too long would drop a legal one-word packet. It also covers a write together with packet end, where an off-by-one shows up as a length short by one, and a packet end on an empty packet, where a wrong design queues a zero-length entry. A pop on the same edge as a write to a full queue is also exercised, because a leaky full check would let a fifth packet in. A threshold load while a packet is open is tried too, since a careless design would retarget the packet halfway.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
package pcc_pkg;
  localparam int LEN_W  = 10;
  localparam int DATA_W = 16;

  typedef logic [LEN_W-1:0]  len_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    len_t  len;
    word_t sig;
  } entry_t;

  typedef enum logic [1:0] {
    CK_NONE   = 2'd0,
    CK_AUTO   = 2'd1,
    CK_MANUAL = 2'd2
  } commit_e;

  localparam len_t LEN_MAX = {LEN_W{1'b1}};

  // word count after this edge
  function automatic len_t count_after(len_t c, logic acc);
    return c + len_t'(acc);
  endfunction

  // data signature after this edge
  function automatic word_t sig_after(word_t s, logic acc, word_t d);
    return acc ? (s ^ d) : s;
  endfunction

  // threshold reached by the word accepted on this edge
  function automatic logic reaches_threshold(logic en, logic acc, len_t nxt, len_t thr);
    return en & acc & (thr != '0) & (nxt == thr);
  endfunction
endpackage

// File: rtl/pcc_word_tracker.sv
`timescale 1ns/1ps
module pcc_word_tracker
  import pcc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_acc,
  input  word_t wr_data,
  input  logic  clear,
  output len_t  cur_count,
  output len_t  next_count,
  output word_t next_sig
);
  word_t cur_sig;

  assign next_count = count_after(cur_count, wr_acc);
  assign next_sig   = sig_after(cur_sig, wr_acc, wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_count <= '0;
      cur_sig   <= '0;
    end else if (clear) begin
      cur_count <= '0;
      cur_sig   <= '0;
    end else begin
      cur_count <= next_count;
      cur_sig   <= next_sig;
    end
  end
endmodule

// File: rtl/pcc_commit_guard.sv
`timescale 1ns/1ps
module pcc_commit_guard
  import pcc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    auto_en,
  input  logic    wr_acc,
  input  logic    pe_req,
  input  logic    room,
  input  len_t    next_count,
  input  len_t    auto_len,
  output logic    auto_hit,
  output logic    manual_hit,
  output logic    too_close,
  output commit_e kind,
  output logic    pe_err
);
  logic auto_d1;

  assign auto_hit   = reaches_threshold(auto_en, wr_acc, next_count, auto_len);
  assign too_close  = pe_req & (auto_hit | auto_d1);
  assign manual_hit = pe_req & ~too_close & room & (next_count != '0);

  always_comb begin
    if (auto_hit)        kind = CK_AUTO;
    else if (manual_hit) kind = CK_MANUAL;
    else                 kind = CK_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_d1 <= 1'b0;
      pe_err  <= 1'b0;
    end else begin
      auto_d1 <= auto_hit;
      if (too_close) pe_err <= 1'b1;
    end
  end
endmodule

// File: rtl/pcc_threshold_reg.sv
`timescale 1ns/1ps
module pcc_threshold_reg
  import pcc_pkg::*;
#(
  parameter int RST_VAL = 512
)(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic idle,
  input  len_t value,
  output len_t auto_len
);
  always_ff @(posedge clk) begin
    if (!rst_n)            auto_len <= len_t'(RST_VAL);
    else if (load && idle) auto_len <= value;
  end
endmodule

// File: rtl/pcc_len_queue.sv
`timescale 1ns/1ps
module pcc_len_queue
  import pcc_pkg::*;
#(
  parameter int DEPTH = 4
)(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push,
  input  entry_t din,
  input  logic   pop,
  output entry_t head,
  output logic   empty,
  output logic   full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = PTR_W + 1;

  logic [PTR_W-1:0] wptr, rptr;
  logic [OCC_W-1:0] occ;
  entry_t           mem [DEPTH];
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (occ == OCC_W'(DEPTH));
  assign empty   = (occ == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wptr == PTR_W'(i))) mem[i] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (do_push) wptr <= ptr_next(wptr);
      if (do_pop)  rptr <= ptr_next(rptr);
      occ <= occ + OCC_W'(do_push) - OCC_W'(do_pop);
    end
  end
endmodule

// File: rtl/pkt_commit_ctrl.sv
`timescale 1ns/1ps
module pkt_commit_ctrl
  import pcc_pkg::*;
#(
  parameter int QDEPTH       = 4,
  parameter int ADDR_W       = 2,
  parameter int EP_ADDR      = 0,
  parameter int AUTO_LEN_RST = 512
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              thr_load,
  input  logic [LEN_W-1:0]  thr_value,
  input  logic [ADDR_W-1:0] ep_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pkt_end,
  input  logic              pop,
  output logic [LEN_W-1:0]  pop_len,
  output logic [DATA_W-1:0] pop_sig,
  output logic              q_empty,
  output logic              q_full,
  output logic [LEN_W-1:0]  cur_count,
  output logic [LEN_W-1:0]  auto_len,
  output logic              pe_err
);
  // named internal events, observed by the checker
  logic    ep_sel;
  logic    wr_acc;
  logic    pe_req;
  logic    auto_hit;
  logic    manual_hit;
  logic    too_close;
  logic    commit;
  commit_e kind;
  len_t    next_count;
  word_t   next_sig;
  entry_t  push_entry;
  entry_t  head;

  assign ep_sel = (ep_addr == ADDR_W'(EP_ADDR));
  assign wr_acc = wr_en & ep_sel & ~q_full & (cur_count != LEN_MAX);
  assign pe_req = pkt_end & ep_sel;
  assign commit = (kind != CK_NONE);

  assign push_entry = '{len: next_count, sig: next_sig};

  pcc_word_tracker u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_acc     (wr_acc),
    .wr_data    (wr_data),
    .clear      (commit),
    .cur_count  (cur_count),
    .next_count (next_count),
    .next_sig   (next_sig)
  );

  pcc_commit_guard u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_en    (auto_en),
    .wr_acc     (wr_acc),
    .pe_req     (pe_req),
    .room       (~q_full),
    .next_count (next_count),
    .auto_len   (auto_len),
    .auto_hit   (auto_hit),
    .manual_hit (manual_hit),
    .too_close  (too_close),
    .kind       (kind),
    .pe_err     (pe_err)
  );

  pcc_threshold_reg #(.RST_VAL(AUTO_LEN_RST)) u_thr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (thr_load),
    .idle     (cur_count == '0),
    .value    (thr_value),
    .auto_len (auto_len)
  );

  pcc_len_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (commit),
    .din   (push_entry),
    .pop   (pop),
    .head  (head),
    .empty (q_empty),
    .full  (q_full)
  );

  assign pop_len = head.len;
  assign pop_sig = head.sig;
endmodule

// File: rtl/pcc_checker.sv
`timescale 1ns/1ps
module pcc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       auto_hit,
  input logic       manual_hit,
  input logic       too_close,
  input logic       commit,
  input logic       pe_err,
  input logic       q_empty,
  input logic       q_full,
  input logic [9:0] cur_count,
  input logic [9:0] auto_len
);
  // R1
  auto_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_hit |=> (cur_count == '0));

  // R4
  window_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    too_close |=> pe_err);

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_err |=> pe_err);

  // R4
  no_manual_after_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_hit |=> !manual_hit);

  // R7
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !commit);

  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_empty && q_full));

  // R8
  thr_load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(auto_len) |-> ($past(cur_count) == '0));
endmodule

bind pkt_commit_ctrl pcc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .auto_hit   (auto_hit),
  .manual_hit (manual_hit),
  .too_close  (too_close),
  .commit     (commit),
  .pe_err     (pe_err),
  .q_empty    (q_empty),
  .q_full     (q_full),
  .cur_count  (cur_count),
  .auto_len   (auto_len)
);

// File: tb/pkt_commit_ctrl_bench.sv
`timescale 1ns/1ps
module pkt_commit_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        auto_en = 1'b1;
  logic        thr_load = 1'b0;
  logic [9:0]  thr_value = '0;
  logic [1:0]  ep_addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        pkt_end = 1'b0;
  logic        pop = 1'b0;
  logic [9:0]  pop_len;
  logic [15:0] pop_sig;
  logic        q_empty, q_full;
  logic [9:0]  cur_count;
  logic [9:0]  auto_len;
  logic        pe_err;

  always #4 clk = ~clk;

  pkt_commit_ctrl u_pkt_commit_ctrl (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .thr_load(thr_load),
    .thr_value(thr_value), .ep_addr(ep_addr), .wr_en(wr_en), .wr_data(wr_data),
    .pkt_end(pkt_end), .pop(pop), .pop_len(pop_len), .pop_sig(pop_sig),
    .q_empty(q_empty), .q_full(q_full), .cur_count(cur_count),
    .auto_len(auto_len), .pe_err(pe_err)
  );

  int compared = 0;
  int mismatched = 0;
  string tag = "R10";
  bit done = 0;

  // reference state
  int m_cnt, m_sig, m_thr, m_occ;
  bit m_ad1, m_err;
  int mq_len [4];
  int mq_sig [4];

  task automatic check(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("cur_count", int'(cur_count), m_cnt);
    check("q_empty", int'(q_empty), int'(m_occ == 0));
    check("q_full", int'(q_full), int'(m_occ == 4));
    check("pe_err", int'(pe_err), int'(m_err));
    check("auto_len", int'(auto_len), m_thr);
    if (m_occ > 0) begin
      check("pop_len", int'(pop_len), mq_len[0]);
      check("pop_sig", int'(pop_sig), mq_sig[0]);
    end
  endtask

  function automatic bit window_hit(bit pe_ok, bit ah, bit ad1);
    return pe_ok && (ah || ad1);
  endfunction

  // one clock: drive at negedge, predict, compare at next negedge
  task automatic step(bit w, int d, bit pe, int a, bit p, bit lw, int lv);
    bit sel, wacc, ah, tc, mh, push, popok, pr;
    int nc, ns;
    wr_en = w; wr_data = 16'(d); pkt_end = pe; ep_addr = 2'(a);
    pop = p; thr_load = lw; thr_value = 10'(lv);
    sel   = (a == 0);
    wacc  = w && sel && (m_occ < 4) && (m_cnt != 1023);
    nc    = m_cnt + int'(wacc);
    ns    = wacc ? (m_sig ^ (d & 16'hFFFF)) : m_sig;
    ah    = auto_en && wacc && (m_thr != 0) && (nc == m_thr);
    pr    = pe && sel;
    tc    = window_hit(pr, ah, m_ad1);
    mh    = pr && !tc && (nc != 0) && (m_occ < 4);
    push  = ah || mh;
    popok = p && (m_occ > 0);
    if (tc) m_err = 1;
    if (lw && m_cnt == 0) m_thr = lv & 10'h3FF;
    if (popok) begin
      for (int i = 0; i < 3; i++) begin
        mq_len[i] = mq_len[i+1];
        mq_sig[i] = mq_sig[i+1];
      end
      m_occ--;
    end
    if (push) begin
      mq_len[m_occ] = nc;
      mq_sig[m_occ] = ns;
      m_occ++;
    end
    m_cnt = push ? 0 : nc;
    m_sig = push ? 0 : ns;
    m_ad1 = ah;
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; pkt_end = 0; pop = 0; thr_load = 0; ep_addr = 0;
    m_cnt = 0; m_sig = 0; m_thr = 512; m_occ = 0; m_ad1 = 0; m_err = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(int d);
    step(1, d, 0, 0, 0, 0, 0);
  endtask

  task automatic idle_pop();
    step(0, 0, 0, 0, 1, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    tag = "R10";
    compare_all();

    tag = "R8";
    step(0, 0, 0, 0, 0, 1, 4);

    tag = "R1/R9";
    wr(1); wr(2); wr(3); wr(4);
    idle_pop();

    tag = "R2";
    wr(5); wr(6); wr(7); wr(8);
    wr(16'h00A5);
    step(0, 0, 1, 0, 0, 0, 0);
    idle_pop(); idle_pop();

    tag = "R5";
    step(0, 0, 1, 0, 0, 0, 0);

    tag = "R3";
    wr(16'h1111); wr(16'h2222);
    step(1, 16'h4444, 1, 0, 0, 0, 0);
    idle_pop();

    tag = "R6";
    step(1, 16'h7777, 1, 1, 0, 0, 0);
    step(1, 16'h7777, 0, 3, 0, 0, 0);
    step(0, 0, 1, 2, 0, 0, 0);

    tag = "R4";
    wr(9); wr(10); wr(11); wr(12);
    step(1, 16'h00C3, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    idle_pop(); idle_pop();

    do_reset();
    tag = "R4";
    step(0, 0, 0, 0, 0, 1, 4);
    wr(21); wr(22); wr(23);
    step(1, 24, 1, 0, 0, 0, 0);
    idle_pop();

    tag = "R8";
    wr(31);
    step(0, 0, 0, 0, 0, 1, 6);
    step(0, 0, 1, 0, 0, 0, 0);
    idle_pop();

    tag = "R7";
    for (int i = 0; i < 4; i++) step(1, 40 + i, 1, 0, 0, 0, 0);
    step(1, 99, 1, 0, 0, 0, 0);
    step(1, 98, 1, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) idle_pop();
    idle_pop();

    tag = "R11";
    auto_en = 0;
    for (int i = 0; i < 1025; i++) wr(i);
    step(0, 0, 1, 0, 0, 0, 0);
    idle_pop();
    auto_en = 1;

    do_reset();
    tag = "R7";
    for (int n = 0; n < 4000; n++) begin
      bit w, pe, p, lw;
      int a;
      if (($urandom % 200) == 0) auto_en = ~auto_en;
      w  = ($urandom % 10) < 6;
      pe = ($urandom % 10) == 0;
      p  = ($urandom % 10) < 4;
      lw = ($urandom % 20) == 0;
      a  = (($urandom % 8) == 0) ? int'($urandom % 4) : 0;
      step(w, int'($urandom % 65536), pe, a, p, lw, int'($urandom % 8));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule